// File: doc/BRIEF.md
# Burst Column Order Generator

This block sits in the read path of a DRAM-style controller. A one-cycle read pulse is sampled together with a starting column. From that pulse the block produces the column address of every beat of the burst, one beat per clock. Along with the address it gives a valid strobe placed where the matching read data would arrive for the programmed CAS latency, a flag on the final beat, and a busy indication.

Beats are reordered only inside the aligned window of the burst length. The column bits above the window are copied unchanged from the starting column. Two orderings exist. The sequential order counts upward and wraps inside the window. The interleaved order XORs the beat number into the low column bits.

The burst length, the ordering and the latency come from a small mode register with its own write strobe. A read uses the settings held at the moment it is sampled. A later mode write does not affect a burst that is already running.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high reset drives `busy`, `beat_valid` and `beat_last` low. It loads the default mode: sequential ordering, burst length 4, CAS latency 3.
- R2: When `cfg_we` is high at a clock edge and the fields are supported, the mode takes effect for reads sampled at later edges. The fields are: `cfg_ilv` (0 = sequential, 1 = interleaved); `cfg_bl_log` = log2 of the burst length (1 = 2 beats, 2 = 4, 3 = 8, 4 = 16); `cfg_cl` = CAS latency in cycles. A read sampled at the same edge as the write uses the old mode.
- R3: With sequential ordering, beat i carries low window bits equal to (start + i) mod BL, so the low bits wrap inside the window. Example: BL 16, start 5 gives 5,6,…,F,0,…,4.
- R4: With interleaved ordering, beat i carries low window bits equal to start XOR i. Example: BL 16, start 5 gives 5,4,7,6,1,0,3,2,D,C,F,E,9,8,B,A.
- R5: Only the low log2(BL) column bits are reordered. All higher column bits equal those of the starting column on every beat.
- R6: A read sampled at edge n shows its first beat on `beat_col`/`beat_valid` right after edge n+CL−1. Later beats follow on consecutive cycles with no gap.
- R7: `beat_last` is high exactly on the final beat of a burst. `beat_valid` is low in the cycle after the final beat unless a new burst is delivering.
- R8: `busy` rises right after the edge that samples a read. It stays high through the cycle that shows the final beat, and falls at the following edge.
- R9: A read sampled while a burst is in progress ends the old burst at once. From the next cycle no beat of the old burst appears, and the new burst follows the timing of R6.
- R10: A mode write whose `cfg_bl_log` is outside 1..4, or whose `cfg_cl` is not 2 or 3, is ignored entirely, including its `cfg_ilv` field. The previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_ilv | input | 1 | Ordering: 0 sequential, 1 interleaved |
| cfg_bl_log | input | 3 | log2 of burst length, 1..4 valid |
| cfg_cl | input | 2 | CAS latency, 2 or 3 valid |
| rd_start | input | 1 | Read command pulse, sampled at the clock edge |
| rd_col | input | COL_W | Starting column of the read |
| beat_col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | Current beat is valid |
| beat_last | output | 1 | Current beat is the final one of the burst |
| busy | output | 1 | A burst is pending or being delivered |

## Verification
The bench takes the edge that samples a read as edge n. It then expects `busy` high and `beat_valid` low right after that edge. It expects no valid beat until the edge n+CL−1, after which one beat must appear per cycle for exactly BL cycles. `busy` and `beat_valid` must then be low one cycle after the final beat. All outputs are read at the falling edge, half a cycle after the rising edge that registers them, and the bench counts falling edges from the command to know which beat is due. Mode writes take effect one edge after their strobe, so each test writes the mode and only then issues the read. One test writes and reads in the same edge to confirm the old mode is used.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;

  localparam int MODE_BL_W = 3;
  localparam int MODE_CL_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } bseq_state_e;

  typedef struct packed {
    logic                 ilv;
    logic [MODE_BL_W-1:0] bl_log;
    logic [MODE_CL_W-1:0] cl;
  } bseq_mode_t;

endpackage

// File: rtl/bseq_mode_reg.sv
`timescale 1ns/1ps
module bseq_mode_reg
  import bseq_pkg::*;
#(
  parameter int MAX_BL_LOG = 4,
  parameter int CL_MIN     = 2,
  parameter int CL_MAX     = 3,
  parameter int DEF_BL_LOG = 2,
  parameter int DEF_CL     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_ilv,
  input  logic [MODE_BL_W-1:0] wr_bl_log,
  input  logic [MODE_CL_W-1:0] wr_cl,
  output bseq_mode_t           mode_q
);

  localparam logic [MODE_BL_W-1:0] BL_HI  = MODE_BL_W'(MAX_BL_LOG);
  localparam logic [MODE_CL_W-1:0] CL_LO  = MODE_CL_W'(CL_MIN);
  localparam logic [MODE_CL_W-1:0] CL_HI  = MODE_CL_W'(CL_MAX);
  localparam logic [MODE_BL_W-1:0] BL_DEF = MODE_BL_W'(DEF_BL_LOG);
  localparam logic [MODE_CL_W-1:0] CL_DEF = MODE_CL_W'(DEF_CL);

  logic bl_ok;
  logic cl_ok;

  always_comb begin
    bl_ok = (wr_bl_log != '0) && (wr_bl_log <= BL_HI);
    cl_ok = (wr_cl >= CL_LO) && (wr_cl <= CL_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q.ilv    <= 1'b0;
      mode_q.bl_log <= BL_DEF;
      mode_q.cl     <= CL_DEF;
    end else if (wr_en && bl_ok && cl_ok) begin
      mode_q.ilv    <= wr_ilv;
      mode_q.bl_log <= wr_bl_log;
      mode_q.cl     <= wr_cl;
    end
  end

endmodule

// File: rtl/bseq_order.sv
`timescale 1ns/1ps
module bseq_order
  import bseq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int MAX_BL_LOG = 4,
  localparam int IDX_W     = MAX_BL_LOG
) (
  input  logic [COL_W-1:0]     start_col,
  input  logic [IDX_W-1:0]     beat_idx,
  input  logic [MODE_BL_W-1:0] bl_log,
  input  logic                 ilv,
  output logic [COL_W-1:0]     col
);

  logic [IDX_W-1:0] seq_low;
  logic [IDX_W-1:0] ilv_low;
  logic [IDX_W-1:0] pick_low;

  always_comb begin
    seq_low  = start_col[IDX_W-1:0] + beat_idx;
    ilv_low  = start_col[IDX_W-1:0] ^ beat_idx;
    pick_low = ilv ? ilv_low : seq_low;
  end

  for (genvar b = 0; b < IDX_W; b++) begin : g_low
    logic in_win;
    assign in_win = (MODE_BL_W'(b) < bl_log);
    assign col[b] = in_win ? pick_low[b] : start_col[b];
  end

  if (COL_W > IDX_W) begin : g_high
    assign col[COL_W-1:IDX_W] = start_col[COL_W-1:IDX_W];
  end

endmodule

// File: rtl/bseq_ctrl.sv
`timescale 1ns/1ps
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int MAX_BL_LOG = 4,
  parameter int CL_MIN     = 2,
  parameter int CL_MAX     = 3,
  localparam int IDX_W     = MAX_BL_LOG,
  localparam int CL_W      = $clog2(CL_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_start,
  input  logic [COL_W-1:0]     rd_col,
  input  bseq_mode_t           mode_q,
  input  logic [COL_W-1:0]     col_in,
  output logic [COL_W-1:0]     cur_start,
  output logic [IDX_W-1:0]     cur_idx,
  output logic [MODE_BL_W-1:0] cur_bl_log,
  output logic                 cur_ilv,
  output logic [COL_W-1:0]     beat_col,
  output logic                 beat_valid,
  output logic                 beat_last,
  output logic                 busy
);

  bseq_state_e      state;
  logic [CL_W-1:0]  wait_cnt;
  logic [IDX_W-1:0] last_idx;
  logic             emit;
  logic             emit_last;

  always_comb begin
    last_idx  = IDX_W'((32'd1 << cur_bl_log) - 32'd1);
    emit      = ((state == ST_WAIT) && (wait_cnt == '0)) || (state == ST_RUN);
    emit_last = emit && (cur_idx == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wait_cnt   <= '0;
      cur_start  <= '0;
      cur_idx    <= '0;
      cur_bl_log <= '0;
      cur_ilv    <= 1'b0;
      beat_col   <= '0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      busy       <= 1'b0;
    end else if (rd_start) begin
      state      <= ST_WAIT;
      wait_cnt   <= CL_W'(mode_q.cl) - CL_W'(CL_MIN);
      cur_start  <= rd_col;
      cur_idx    <= '0;
      cur_bl_log <= mode_q.bl_log;
      cur_ilv    <= mode_q.ilv;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      busy       <= 1'b1;
    end else begin
      busy       <= (state != ST_IDLE);
      beat_valid <= emit;
      beat_last  <= emit_last;
      if (emit) begin
        beat_col <= col_in;
      end
      unique case (state)
        ST_WAIT: begin
          if (wait_cnt == '0) begin
            state   <= emit_last ? ST_IDLE : ST_RUN;
            cur_idx <= cur_idx + 1'b1;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        ST_RUN: begin
          if (emit_last) begin
            state <= ST_IDLE;
          end else begin
            cur_idx <= cur_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
  import bseq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int MAX_BL_LOG = 4,
  parameter int CL_MIN     = 2,
  parameter int CL_MAX     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_ilv,
  input  logic [MODE_BL_W-1:0] cfg_bl_log,
  input  logic [MODE_CL_W-1:0] cfg_cl,
  input  logic                 rd_start,
  input  logic [COL_W-1:0]     rd_col,
  output logic [COL_W-1:0]     beat_col,
  output logic                 beat_valid,
  output logic                 beat_last,
  output logic                 busy
);

  localparam int IDX_W = MAX_BL_LOG;

  bseq_mode_t           mode_q;
  logic [COL_W-1:0]     cur_start;
  logic [IDX_W-1:0]     cur_idx;
  logic [MODE_BL_W-1:0] cur_bl_log;
  logic                 cur_ilv;
  logic [COL_W-1:0]     next_col;

  bseq_mode_reg #(
    .MAX_BL_LOG(MAX_BL_LOG),
    .CL_MIN    (CL_MIN),
    .CL_MAX    (CL_MAX),
    .DEF_BL_LOG(2),
    .DEF_CL    (3)
  ) u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_ilv   (cfg_ilv),
    .wr_bl_log(cfg_bl_log),
    .wr_cl    (cfg_cl),
    .mode_q   (mode_q)
  );

  bseq_order #(
    .COL_W     (COL_W),
    .MAX_BL_LOG(MAX_BL_LOG)
  ) u_order (
    .start_col(cur_start),
    .beat_idx (cur_idx),
    .bl_log   (cur_bl_log),
    .ilv      (cur_ilv),
    .col      (next_col)
  );

  bseq_ctrl #(
    .COL_W     (COL_W),
    .MAX_BL_LOG(MAX_BL_LOG),
    .CL_MIN    (CL_MIN),
    .CL_MAX    (CL_MAX)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rd_start  (rd_start),
    .rd_col    (rd_col),
    .mode_q    (mode_q),
    .col_in    (next_col),
    .cur_start (cur_start),
    .cur_idx   (cur_idx),
    .cur_bl_log(cur_bl_log),
    .cur_ilv   (cur_ilv),
    .beat_col  (beat_col),
    .beat_valid(beat_valid),
    .beat_last (beat_last),
    .busy      (busy)
  );

endmodule

// File: rtl/bseq_checker.sv
`timescale 1ns/1ps
module bseq_checker #(
  parameter int COL_W      = 10,
  parameter int MAX_BL_LOG = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_start,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             busy
);

  // R8: a valid beat is only shown while busy
  a_r8_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> busy);

  // R7: the last flag only marks a valid beat
  a_r7_last_is_valid: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);

  // R7: nothing valid right after the final beat
  a_r7_end_after_last: assert property (@(posedge clk) disable iff (rst)
    beat_last |=> !beat_valid);

  // R9: a sampled read clears the output and raises busy
  a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> (busy && !beat_valid));

  // R6: beats of one burst come on consecutive cycles
  a_r6_no_gap: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last && !rd_start) |=> beat_valid);

  // R8: busy only falls after a final beat
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(beat_last));

  if (COL_W > MAX_BL_LOG) begin : g_upper
    // R5: column bits above the largest window stay fixed inside a burst
    a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
      (beat_valid && !beat_last && !rd_start) |=>
        $stable(beat_col[COL_W-1:MAX_BL_LOG]));
  end

endmodule

bind burst_col_seq bseq_checker #(
  .COL_W     (COL_W),
  .MAX_BL_LOG(MAX_BL_LOG)
) u_bseq_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_start  (rd_start),
  .beat_col  (beat_col),
  .beat_valid(beat_valid),
  .beat_last (beat_last),
  .busy      (busy)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic             cfg_ilv = 1'b0;
  logic [2:0]       cfg_bl_log = 3'd0;
  logic [1:0]       cfg_cl = 2'd0;
  logic             rd_start = 1'b0;
  logic [COL_W-1:0] rd_col = '0;
  logic [COL_W-1:0] beat_col;
  logic             beat_valid;
  logic             beat_last;
  logic             busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ilv(cfg_ilv),
    .cfg_bl_log(cfg_bl_log), .cfg_cl(cfg_cl), .rd_start(rd_start),
    .rd_col(rd_col), .beat_col(beat_col), .beat_valid(beat_valid),
    .beat_last(beat_last), .busy(busy)
  );

  // entry: [15] interleaved, [14:12] log2 BL, [11:10] CL, [9:0] start column
  localparam logic [15:0] VEC [10] = '{
    {1'b0, 3'd4, 2'd2, 10'h005},
    {1'b1, 3'd4, 2'd3, 10'h005},
    {1'b0, 3'd3, 2'd2, 10'h2AD},
    {1'b1, 3'd3, 2'd3, 10'h3F6},
    {1'b0, 3'd1, 2'd3, 10'h101},
    {1'b1, 3'd2, 2'd2, 10'h0C3},
    {1'b0, 3'd2, 2'd3, 10'h1FE},
    {1'b1, 3'd1, 2'd2, 10'h200},
    {1'b1, 3'd4, 2'd2, 10'h3FF},
    {1'b0, 3'd4, 2'd3, 10'h0F0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int start, input int i, input int bl_log, input bit ilv);
    int mask;
    int low;
    mask = (1 << bl_log) - 1;
    low  = ilv ? (start ^ i) : (start + i);
    return (start & ~mask & 'h3FF) | (low & mask);
  endfunction

  // caller stands at a falling edge; returns at a falling edge
  task automatic write_mode(input bit ilv, input int bl_log, input int cl);
    cfg_we = 1'b1; cfg_ilv = ilv; cfg_bl_log = 3'(bl_log); cfg_cl = 2'(cl);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issues a read (optionally with a mode write at the same edge) and checks the whole burst
  task automatic run_read(input int start, input bit ilv, input int bl_log, input int cl,
                          input bit also_wr, input bit w_ilv, input int w_bl, input int w_cl);
    int bl;
    bl = 1 << bl_log;
    rd_start = 1'b1; rd_col = COL_W'(start);
    if (also_wr) begin
      cfg_we = 1'b1; cfg_ilv = w_ilv; cfg_bl_log = 3'(w_bl); cfg_cl = 2'(w_cl);
    end
    @(posedge clk);
    @(negedge clk);
    rd_start = 1'b0; cfg_we = 1'b0;
    chk(busy == 1'b1, "R8 busy after read", int'(busy), 1);
    for (int w = 0; w < cl - 1; w++) begin
      chk(beat_valid == 1'b0, "R6 no beat before CL", int'(beat_valid), 0);
      @(negedge clk);
    end
    for (int i = 0; i < bl; i++) begin
      chk(beat_valid == 1'b1, "R6 beat due", int'(beat_valid), 1);
      if (ilv)
        chk(int'(beat_col) == exp_col(start, i, bl_log, 1'b1), "R4 R5 interleaved column",
            int'(beat_col), exp_col(start, i, bl_log, 1'b1));
      else
        chk(int'(beat_col) == exp_col(start, i, bl_log, 1'b0), "R3 R5 sequential column",
            int'(beat_col), exp_col(start, i, bl_log, 1'b0));
      chk(beat_last == (i == bl - 1), "R7 last flag", int'(beat_last), int'(i == bl - 1));
      chk(busy == 1'b1, "R8 busy during burst", int'(busy), 1);
      @(negedge clk);
    end
    chk(beat_valid == 1'b0, "R7 valid low after last", int'(beat_valid), 0);
    chk(busy == 1'b0, "R8 busy low after last", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(beat_valid == 1'b0, "R1 valid reset", int'(beat_valid), 0);
    chk(beat_last == 1'b0, "R1 last reset", int'(beat_last), 0);
    // R1: defaults sequential, BL 4, CL 3
    run_read('h00E, 1'b0, 2, 3, 1'b0, 1'b0, 0, 0);

    // R2 R3 R4 R5 R6: table walk
    foreach (VEC[k]) begin
      write_mode(VEC[k][15], int'(VEC[k][14:12]), int'(VEC[k][11:10]));
      run_read(int'(VEC[k][9:0]), VEC[k][15], int'(VEC[k][14:12]), int'(VEC[k][11:10]),
               1'b0, 1'b0, 0, 0);
    end

    // R10: unsupported writes leave interleaved BL8 CL2 in force
    write_mode(1'b1, 3, 2);
    write_mode(1'b0, 0, 2);
    write_mode(1'b0, 5, 3);
    write_mode(1'b0, 7, 2);
    write_mode(1'b0, 2, 1);
    write_mode(1'b0, 2, 0);
    run_read('h15A, 1'b1, 3, 2, 1'b0, 1'b0, 0, 0);

    // R2: write at the read edge does not affect that read, only the next one
    write_mode(1'b0, 2, 2);
    run_read('h033, 1'b0, 2, 2, 1'b1, 1'b1, 4, 3);
    run_read('h033, 1'b1, 4, 3, 1'b0, 1'b0, 0, 0);

    // R9: restart during a sequential BL16 CL3 burst
    write_mode(1'b0, 4, 3);
    rd_start = 1'b1; rd_col = COL_W'('h040);
    @(posedge clk);
    @(negedge clk);
    rd_start = 1'b0;
    repeat (2) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(beat_valid == 1'b1 && int'(beat_col) == 'h043, "R9 old burst running",
        int'(beat_col), 'h043);
    run_read('h10B, 1'b0, 4, 3, 1'b0, 1'b0, 0, 0);

    // R9: restart with CL2 interleaved, new read one cycle into the burst
    write_mode(1'b1, 3, 2);
    rd_start = 1'b1; rd_col = COL_W'('h207);
    @(posedge clk);
    @(negedge clk);
    rd_start = 1'b0;
    @(negedge clk);
    chk(beat_valid == 1'b1 && int'(beat_col) == 'h207, "R9 first beat of old burst",
        int'(beat_col), 'h207);
    run_read('h2F1, 1'b1, 3, 2, 1'b0, 1'b0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule